// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial bus that acts like a small byte-wide serial EEPROM. Its size is a parameter from 128 to 2048 bytes. The bus lines reach it as plain inputs sampled by the system clock. It answers by pulling SDA low through a single open-drain enable output. A controller selects it with a select byte, sets its internal byte pointer, and then either streams bytes into the array or reads them back. The pointer advances after each byte and wraps at the top of the array.

After every stop that ends a transfer in which data was stored, the block imitates the programming time of a real cell array. For a set number of clock cycles it ignores selection, and the controller finds out that the write has finished by polling for an acknowledge. A write-protect input blocks all stores. Three strap inputs set the sub-address, and sizes above 256 bytes borrow the low strap positions as high pointer bits.

Top module: `i2c_ee_slave`

## Requirements
- R1: A select byte is acknowledged only if its bits 7:4 are 1010 and the sub-address field (bits 3:1) matches `strap_i` on every position that is not an address position. With 256 bytes or fewer, all three positions are compared. With 512, 1024 or 2048 bytes, the lowest 1, 2 or 3 positions of the field are not compared.
- R2: On an acknowledged select, the address positions of the select byte become the pointer bits above bit 7. Bit 1 of the select byte goes to pointer bit 8, and so on upward. Bit 0 of the select byte gives the direction: 1 is read, 0 is write.
- R3: After a write select, the first byte received is acknowledged and replaces pointer bits 7:0.
- R4: Each further byte of a write transfer is acknowledged and stored at the pointer, and then the pointer increments.
- R5: A read transfer returns the byte at the pointer, most significant bit first, and then increments the pointer. The pointer wraps from the last location to 0. The pointer keeps its value from one transfer to the next.
- R6: The target keeps sending bytes while the controller acknowledges them (SDA low in the ninth bit). After a not-acknowledge, it leaves SDA released until the next start.
- R7: A stop that ends a write transfer with at least one stored byte starts a busy period of `WR_CYCLES` clocks. During that period SDA is never pulled, so every select is not-acknowledged. A stop after a transfer that stored nothing starts no busy period.
- R8: While `wp_i` is high, data bytes are not-acknowledged and not stored, the pointer does not move, and no busy period follows. When `wp_i` is low, writes are allowed.
- R9: A start or repeated start, even in the middle of a byte, restarts reception of a select byte. SDA is released in the cycle after a start or stop is detected.
- R10: After reset every location reads 0xFF, the pointer is 0 and SDA is released.
- R11: The SDA pull changes only in the cycle after an SCL falling edge, a start or a stop is detected, so it stays steady while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | High to drive SDA low (open-drain enable) |
| wp_i | input | 1 | Write protect, high blocks all stores |
| strap_i | input | 3 | Sub-address straps |

## Verification
The bench builds the block with 512 bytes. At that size bit 1 of the select byte is a real address bit, while bits 3:2 are still compared with the straps, so both sides of R1 and R2 are reached in one build. It also lets a read run across the top of the array and wrap to 0. The busy period is shortened to 400 cycles. That is long enough that the first poll after a write is always refused and short enough that a later poll succeeds, so R7 can be observed within a few select attempts.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXEND,
      ST_ACK,
      ST_TX,
      ST_TXACK
   } ee_state_t;

   typedef enum logic [1:0] {
      RX_SEL,
      RX_WORD,
      RX_DATA
   } rx_kind_t;

   localparam logic [3:0] DEV_TYPE = 4'b1010;
   localparam logic [7:0] ERASED   = 8'hFF;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s      = scl_pipe[STAGES-1];
   assign sda_o      = sda_pipe[STAGES-1];
   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int         DEPTH = 256,
   parameter logic [7:0] INIT  = 8'hFF,
   localparam int        AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o
);

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= INIT;
      end else if (we_i) begin
         cells[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/i2c_ee_wtimer.sv
module i2c_ee_wtimer #(
   parameter int  CYCLES = 625000,
   localparam int CW     = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic busy_o
);

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left <= '0;
      else if (kick_i)         left <= CW'(CYCLES);
      else if (left != '0)     left <= left - 1'b1;
   end

   assign busy_o = (left != '0);

endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
   import i2c_ee_pkg::*;
#(
   parameter int  MEM_BYTES   = 256,
   parameter int  WR_CYCLES   = 625000,
   parameter int  SYNC_STAGES = 2,
   localparam int AW          = $clog2(MEM_BYTES),
   localparam int HI          = (AW > 8) ? AW - 8 : 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic       wp_i,
   input  logic [2:0] strap_i
);

   if (MEM_BYTES < 128 || MEM_BYTES > 2048 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_size
      $error("MEM_BYTES must be a power of two from 128 to 2048");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WR_CYCLES < 1) begin : g_bad_wr
      $error("WR_CYCLES must be at least 1");
   end

   localparam logic [2:0] CMP_MASK = 3'(3'b111 << HI);

   logic          sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   ee_state_t     state;
   rx_kind_t      kind;
   logic [2:0]    bit_cnt;
   logic [6:0]    shreg;
   logic [7:0]    rx_byte;
   logic [7:0]    tx_sh;
   logic          ack_drv, is_read, mack, wrote_any;
   logic [AW-1:0] ptr, sel_ptr, word_ptr;
   logic          sel_match, byte_done;
   logic          mem_we, busy, wr_kick;
   logic [7:0]    rdata;

   i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_evt),
      .stop_o     (stop_evt)
   );

   i2c_ee_mem #(.DEPTH(MEM_BYTES), .INIT(ERASED)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .waddr_i (ptr),
      .wdata_i (rx_byte),
      .raddr_i (ptr),
      .rdata_o (rdata)
   );

   i2c_ee_wtimer #(.CYCLES(WR_CYCLES)) u_wtimer (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick_i (wr_kick),
      .busy_o (busy)
   );

   assign rx_byte   = {shreg, sda_s};
   assign byte_done = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7);
   assign sel_match = (rx_byte[7:4] == DEV_TYPE) &&
                      (((rx_byte[3:1] ^ strap_i) & CMP_MASK) == 3'b000);
   assign mem_we    = byte_done && (kind == RX_DATA) && !wp_i;
   assign wr_kick   = stop_evt && wrote_any;

   if (AW > 8) begin : g_wide
      assign sel_ptr  = {rx_byte[HI:1], ptr[7:0]};
      assign word_ptr = {ptr[AW-1:8], rx_byte};
   end else begin : g_narrow
      assign sel_ptr  = ptr;
      assign word_ptr = rx_byte[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= RX_SEL;
         bit_cnt   <= 3'd0;
         shreg     <= 7'd0;
         tx_sh     <= 8'hFF;
         ack_drv   <= 1'b0;
         is_read   <= 1'b0;
         mack      <= 1'b0;
         wrote_any <= 1'b0;
         ptr       <= '0;
      end else if (start_evt) begin
         state   <= ST_RX;
         kind    <= RX_SEL;
         bit_cnt <= 3'd0;
         ack_drv <= 1'b0;
      end else if (stop_evt) begin
         state     <= ST_IDLE;
         ack_drv   <= 1'b0;
         wrote_any <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg   <= rx_byte[6:0];
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) begin
                     state <= ST_RXEND;
                     unique case (kind)
                        RX_SEL: begin
                           ack_drv <= sel_match && !busy;
                           is_read <= rx_byte[0];
                           if (sel_match && !busy) ptr <= sel_ptr;
                        end
                        RX_WORD: begin
                           ack_drv <= 1'b1;
                           ptr     <= word_ptr;
                        end
                        default: begin
                           ack_drv <= !wp_i;
                           if (!wp_i) begin
                              ptr       <= ptr + 1'b1;
                              wrote_any <= 1'b1;
                           end
                        end
                     endcase
                  end
               end
            end
            ST_RXEND: begin
               if (scl_fall) state <= ST_ACK;
            end
            ST_ACK: begin
               if (scl_fall) begin
                  ack_drv <= 1'b0;
                  bit_cnt <= 3'd0;
                  if (!ack_drv) begin
                     state <= ST_IDLE;
                  end else if (kind == RX_SEL && is_read) begin
                     state <= ST_TX;
                     tx_sh <= rdata;
                  end else begin
                     state <= ST_RX;
                     kind  <= (kind == RX_SEL) ? RX_WORD : RX_DATA;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) begin
                     state <= ST_TXACK;
                     ptr   <= ptr + 1'b1;
                  end else begin
                     tx_sh <= {tx_sh[6:0], 1'b1};
                  end
               end
            end
            ST_TXACK: begin
               if (scl_rise) mack <= !sda_s;
               if (scl_fall) begin
                  if (mack) begin
                     state   <= ST_TX;
                     tx_sh   <= rdata;
                     bit_cnt <= 3'd0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull_o = ((state == ST_ACK) && ack_drv) ||
                       ((state == ST_TX) && !tx_sh[7]);

endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_fall,
   input logic start_evt,
   input logic stop_evt,
   input logic busy,
   input logic sda_pull
);

   // R7
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_pull);

   // R7
   wcycle_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));

   // R9
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !sda_pull);

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_pull);

   // R11
   drive_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |-> $past(scl_fall || start_evt || stop_evt));

endmodule

bind i2c_ee_slave i2c_ee_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_fall  (scl_fall),
   .start_evt (start_evt),
   .stop_evt  (stop_evt),
   .busy      (busy),
   .sda_pull  (sda_pull_o)
);

// File: tb/i2c_ee_slave_test.sv
module i2c_ee_slave_test;

   localparam int MEM  = 512;
   localparam int WRC  = 400;
   localparam int HALF = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       wp = 1'b0;
   logic [2:0] strap = 3'b101;
   logic       pull;
   logic       sda_line;

   assign sda_line = sda_m & ~pull;

   i2c_ee_slave #(.MEM_BYTES(MEM), .WR_CYCLES(WRC)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_line),
      .sda_pull_o (pull),
      .wp_i       (wp),
      .strap_i    (strap)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] ref_mem [MEM];
   int ref_ptr = 0;
   int stop_cyc = -100000;
   bit ref_wrote = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act_v, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one SCL period; compares the pull on every clock while SCL is high (R11)
   task automatic bus_bit(input bit mbit, input bit exp_pull, input bit check, input string req, output bit line);
      tick(3);
      sda_m = mbit;
      tick(HALF - 3);
      scl = 1'b1;
      tick(4);
      line = sda_line;
      for (int k = 0; k < HALF - 4; k++) begin
         if (check) chk(pull == exp_pull, req, "sda pull (R11 steady high phase)", pull, exp_pull);
         tick(1);
      end
      scl = 1'b0;
   endtask

   task automatic bus_start();
      if (!scl) begin
         tick(3);
         sda_m = 1'b1;
         tick(HALF - 3);
         scl = 1'b1;
         tick(HALF);
      end
      sda_m = 1'b0;
      tick(HALF);
      scl = 1'b0;
   endtask

   task automatic bus_stop(input string req);
      tick(3);
      sda_m = 1'b0;
      tick(HALF - 3);
      scl = 1'b1;
      tick(HALF);
      sda_m = 1'b1;
      if (ref_wrote) stop_cyc = cyc;
      ref_wrote = 0;
      tick(HALF);
      chk(pull == 1'b0, req, "released after stop", pull, 0);
   endtask

   // exp_ack: 1 ack, 0 nack, -1 not checked
   task automatic send_byte(input logic [7:0] b, input int exp_ack, input string req, output bit acked);
      bit l;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, 1'b1, req, l);
      bus_bit(1'b1, exp_ack == 1, exp_ack >= 0, req, l);
      acked = !l;
      if (exp_ack >= 0) chk(acked == (exp_ack == 1), req, "acknowledge", acked, exp_ack);
   endtask

   function automatic int busy_state(input int at_cyc);
      int e;
      e = at_cyc + 15 * HALF - stop_cyc;
      if (e < WRC - 30) return 1;
      if (e > WRC + 30) return 0;
      return -1;
   endfunction

   task automatic do_select(input logic [7:0] b, input string req, output bit acked);
      bit match;
      int bs;
      int exp_a;
      match = (b[7:4] == 4'b1010) && (b[3:2] == strap[2:1]);
      bs = busy_state(cyc);
      if (!match) exp_a = 0;
      else if (bs < 0) exp_a = -1;
      else exp_a = (bs == 0) ? 1 : 0;
      send_byte(b, exp_a, req, acked);
      if (acked) ref_ptr = (int'(b[1]) * 256) + (ref_ptr % 256);
   endtask

   task automatic send_word(input logic [7:0] w, input string req);
      bit a;
      send_byte(w, 1, req, a);
      ref_ptr = (ref_ptr / 256) * 256 + int'(w);
   endtask

   task automatic send_data(input logic [7:0] d, input string req);
      bit a;
      send_byte(d, wp ? 0 : 1, req, a);
      if (!wp) begin
         ref_mem[ref_ptr] = d;
         ref_ptr = (ref_ptr + 1) % MEM;
         ref_wrote = 1;
      end
   endtask

   task automatic recv_byte(input bit mack, input string req);
      logic [7:0] got;
      logic [7:0] expd;
      bit l;
      expd = ref_mem[ref_ptr];
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, !expd[i], 1'b1, req, l);
         got[i] = l;
      end
      ref_ptr = (ref_ptr + 1) % MEM;
      bus_bit(!mack, 1'b0, 1'b1, req, l);
      chk(got == expd, req, "read data", got, expd);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit a;
      int tries;
      for (int i = 0; i < MEM; i++) ref_mem[i] = 8'hFF;
      tick(5);
      chk(pull == 1'b0, "R10", "pull in reset", pull, 0);
      rst_n = 1'b1;
      tick(5);
      chk(pull == 1'b0, "R10", "pull after reset", pull, 0);

      // R10 R5 R6: current-address read of erased location 0, then NACK
      bus_start();
      do_select(8'hA9, "R10", a);
      recv_byte(1'b0, "R10");
      bus_stop("R6");

      // R1: wrong device type, wrong straps, uncompared address position
      bus_start();
      do_select(8'hB8, "R1", a);
      bus_start();
      do_select(8'hA4, "R1", a);
      bus_start();
      do_select(8'hAA, "R1", a);
      bus_stop("R1");

      // R2 R3 R4: write three bytes at 0x1FD
      bus_start();
      do_select(8'hAA, "R2", a);
      send_word(8'hFD, "R3");
      send_data(8'h11, "R4");
      send_data(8'h22, "R4");
      send_data(8'h33, "R4");
      bus_stop("R4");

      // R7: poll until acknowledged
      tries = 0;
      a = 0;
      while (!a && tries < 20) begin
         tries++;
         bus_start();
         do_select(8'hA8, "R7", a);
         bus_stop("R7");
      end
      chk(a == 1'b1, "R7", "poll eventually acknowledged", a, 1);
      chk(tries >= 2, "R7", "first poll refused", tries, 2);

      // R5 R2 R6: random read 0x1FE onward, wrap to 0
      bus_start();
      do_select(8'hAA, "R2", a);
      send_word(8'hFE, "R3");
      bus_start();
      do_select(8'hAB, "R2", a);
      recv_byte(1'b1, "R5");
      recv_byte(1'b1, "R5");
      recv_byte(1'b1, "R5");
      recv_byte(1'b0, "R6");
      bus_stop("R6");

      // R7 R9: pointer only, no busy; restart mid-byte; current read
      bus_start();
      do_select(8'hAA, "R7", a);
      send_word(8'hFD, "R3");
      bus_stop("R7");
      bus_start();
      for (int i = 0; i < 3; i++) bus_bit(i[0], 1'b0, 1'b1, "R9", a);
      bus_start();
      do_select(8'hAB, "R9", a);
      chk(a == 1'b1, "R9", "select after mid-byte restart", a, 1);
      recv_byte(1'b1, "R5");
      recv_byte(1'b0, "R5");
      bus_stop("R9");

      // R8: protected write refused, nothing stored, no busy period
      wp = 1'b1;
      bus_start();
      do_select(8'hAA, "R8", a);
      send_word(8'h10, "R8");
      send_data(8'h77, "R8");
      bus_stop("R8");
      wp = 1'b0;
      bus_start();
      do_select(8'hAB, "R8", a);
      chk(a == 1'b1, "R8", "no busy period after refused write", a, 1);
      recv_byte(1'b0, "R8");
      bus_stop("R8");

      tick(20);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule